// File: doc/BRIEF.md
# Paired byte/word register array

This block holds the general registers of a small 8-bit processor core. Six byte registers (B, C, D, E, H, L) sit in three pairs that can also be handled as 16-bit words, next to a 16-bit stack pointer and a 16-bit program counter. Each byte is loaded from the 8-bit internal bus and can be read back onto it. Any 16-bit register can be incremented or decremented in one cycle; the program counter uses this to step past each fetched byte.

Any of the five 16-bit registers can be routed to the memory address output. The high byte goes to a dedicated lane. The low byte shares one lane with data: while the address-latch strobe is high the lane carries the address low byte, and at all other times it carries the data byte offered by the core.

Top module: `pair_regs`

## Requirements
- R1: After reset every byte register, the stack pointer and the program counter read zero.
- R2: With `bw_en` high, `bus_in` is stored at the clock edge in the byte chosen by `bw_sel` (0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=SP high, 7=SP low). With `br_pc` low, `bus_out` shows the byte chosen by `br_sel` with the same encoding, without a clock delay.
- R3: In each pair the first-named register is the high byte. The word select (`w_sel`, `a_sel`) is encoded 0=BC, 1=DE, 2=HL, 3=SP, 4 to 7=PC.
- R4: With `pcw_en` high, `bus_in` is stored in the PC high byte when `pcw_hi`=1, and in the low byte otherwise. With `br_pc` high, `bus_out` shows the PC high byte when `br_pc_hi`=1, and the low byte otherwise.
- R5: With `w_inc` high and `w_dec` low, the word chosen by `w_sel` becomes its value plus one, modulo 2^16, at the next edge. FFFF wraps to 0000.
- R6: With `w_dec` high and `w_inc` low, the chosen word becomes its value minus one, modulo 2^16. 0000 wraps to FFFF.
- R7: With `w_inc` and `w_dec` both high, no word changes.
- R8: A byte write has priority. If a byte write (through `bw_en` or `pcw_en`) lands in the same 16-bit register as an increment or decrement in the same cycle, the increment or decrement is dropped for that cycle. Registers not addressed keep their values.
- R9: With `ale` high, `ad_lane` carries the low byte of the word chosen by `a_sel`. With `ale` low, it carries `lane_data`.
- R10: `addr_hi` always shows the high byte of the word chosen by `a_sel`, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_en | input | 1 | Byte write enable for B..L and SP bytes |
| bw_sel | input | 3 | Byte write select |
| pcw_en | input | 1 | PC byte write enable |
| pcw_hi | input | 1 | PC byte write half: 1 = high |
| bus_in | input | BW | Internal bus data to write |
| br_sel | input | 3 | Byte read select |
| br_pc | input | 1 | Read a PC byte instead |
| br_pc_hi | input | 1 | PC read half: 1 = high |
| bus_out | output | BW | Byte read result |
| w_sel | input | 3 | Word select for increment/decrement |
| w_inc | input | 1 | Increment chosen word |
| w_dec | input | 1 | Decrement chosen word |
| a_sel | input | 3 | Word select for address output |
| ale | input | 1 | Address-latch strobe for the shared lane |
| lane_data | input | BW | Data byte for the shared lane |
| addr_hi | output | BW | Address high byte |
| ad_lane | output | BW | Shared address-low / data lane |

## Verification
The bench builds the block with its default byte width of 8, so words are 16 bits wide. At this width a wrap can be set up by loading two bytes, and one increment or decrement then crosses FFFF/0000. Long random stretches apply byte writes, word steps and increment/decrement collisions to all five words, and the collisions exercise the priority rule. Directed steps pin down the wrap values, the simultaneous increment/decrement case and the pair byte order.

// File: rtl/pair_regs.sv
module pair_regs #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bw_en,
  input  logic [2:0]    bw_sel,
  input  logic          pcw_en,
  input  logic          pcw_hi,
  input  logic [BW-1:0] bus_in,
  input  logic [2:0]    br_sel,
  input  logic          br_pc,
  input  logic          br_pc_hi,
  output logic [BW-1:0] bus_out,
  input  logic [2:0]    w_sel,
  input  logic          w_inc,
  input  logic          w_dec,
  input  logic [2:0]    a_sel,
  input  logic          ale,
  input  logic [BW-1:0] lane_data,
  output logic [BW-1:0] addr_hi,
  output logic [BW-1:0] ad_lane
);
  localparam int WW = 2 * BW;

  logic [BW-1:0] rb [8];
  logic [WW-1:0] pc;
  logic [WW-1:0] w_cur, w_nxt, a_word;
  logic          w_act, blocked;

  always_comb begin
    if (w_sel[2]) w_cur = pc;
    else          w_cur = {rb[{w_sel[1:0], 1'b0}], rb[{w_sel[1:0], 1'b1}]};
    if (a_sel[2]) a_word = pc;
    else          a_word = {rb[{a_sel[1:0], 1'b0}], rb[{a_sel[1:0], 1'b1}]};
  end

  assign w_act   = w_inc ^ w_dec;
  assign w_nxt   = w_inc ? w_cur + 1'b1 : w_cur - 1'b1;
  assign blocked = w_sel[2] ? pcw_en : (bw_en && bw_sel[2:1] == w_sel[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rb[i] <= '0;
      pc <= '0;
    end else begin
      if (w_act && !blocked) begin
        if (w_sel[2]) pc <= w_nxt;
        else begin
          rb[{w_sel[1:0], 1'b0}] <= w_nxt[WW-1:BW];
          rb[{w_sel[1:0], 1'b1}] <= w_nxt[BW-1:0];
        end
      end
      if (bw_en) rb[bw_sel] <= bus_in;
      if (pcw_en) begin
        if (pcw_hi) pc[WW-1:BW] <= bus_in;
        else        pc[BW-1:0]  <= bus_in;
      end
    end
  end

  assign bus_out = br_pc ? (br_pc_hi ? pc[WW-1:BW] : pc[BW-1:0]) : rb[br_sel];
  assign addr_hi = a_word[WW-1:BW];
  assign ad_lane = ale ? a_word[BW-1:0] : lane_data;
endmodule

module pair_regs_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bw_en,
  input logic [2:0]    bw_sel,
  input logic          pcw_en,
  input logic [BW-1:0] bus_in,
  input logic [2:0]    br_sel,
  input logic          br_pc,
  input logic [BW-1:0] bus_out,
  input logic [2:0]    w_sel,
  input logic          w_inc,
  input logic          w_dec,
  input logic [2:0]    a_sel,
  input logic [BW-1:0] addr_hi,
  input logic [2*BW-1:0] pc
);
  assert_pc_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_inc && !w_dec && w_sel[2] && !pcw_en) |=> pc == $past(pc) + 1'b1);

  assert_pc_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dec && !w_inc && w_sel[2] && !pcw_en) |=> pc == $past(pc) - 1'b1);

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_inc && w_dec && !pcw_en) |=> $stable(pc));

  assert_write_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bw_en |=> (br_pc || br_sel != $past(bw_sel) || bus_out == $past(bus_in)));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bw_en && !pcw_en && !(w_inc ^ w_dec)) ##1 (a_sel == $past(a_sel)) |-> $stable(addr_hi));
endmodule

bind pair_regs pair_regs_chk #(.BW(BW)) u_pair_regs_chk (
  .clk(clk), .rst_n(rst_n), .bw_en(bw_en), .bw_sel(bw_sel), .pcw_en(pcw_en),
  .bus_in(bus_in), .br_sel(br_sel), .br_pc(br_pc), .bus_out(bus_out),
  .w_sel(w_sel), .w_inc(w_inc), .w_dec(w_dec), .a_sel(a_sel),
  .addr_hi(addr_hi), .pc(pc)
);

// File: tb/test_pair_regs.sv
module test_pair_regs;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bw_en = 0, pcw_en = 0, pcw_hi = 0, br_pc = 0, br_pc_hi = 0;
  logic w_inc = 0, w_dec = 0, ale = 0;
  logic [2:0] bw_sel = 0, br_sel = 0, w_sel = 0, a_sel = 0;
  logic [7:0] bus_in = 0, lane_data = 0;
  logic [7:0] bus_out, addr_hi, ad_lane;

  logic [7:0]  m [8];
  logic [15:0] mpc;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pair_regs i_pair_regs (
    .clk(clk), .rst_n(rst_n), .bw_en(bw_en), .bw_sel(bw_sel), .pcw_en(pcw_en),
    .pcw_hi(pcw_hi), .bus_in(bus_in), .br_sel(br_sel), .br_pc(br_pc),
    .br_pc_hi(br_pc_hi), .bus_out(bus_out), .w_sel(w_sel), .w_inc(w_inc),
    .w_dec(w_dec), .a_sel(a_sel), .ale(ale), .lane_data(lane_data),
    .addr_hi(addr_hi), .ad_lane(ad_lane)
  );

  function automatic logic [15:0] mword(input logic [2:0] k);
    if (k >= 3'd4) return mpc;
    return {m[2*k], m[2*k+1]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    logic [15:0] aw;
    aw = mword(a_sel);
    if (br_pc) check("R4", bus_out, br_pc_hi ? mpc[15:8] : mpc[7:0]);
    else       check("R2", bus_out, m[br_sel]);
    check("R10", addr_hi, aw[15:8]);
    check("R9", ad_lane, ale ? aw[7:0] : lane_data);
  endtask

  task automatic model_step();
    logic [15:0] w;
    logic blk;
    w = mword(w_sel);
    blk = w_sel[2] ? pcw_en : (bw_en && bw_sel[2:1] == w_sel[1:0]);
    if ((w_inc ^ w_dec) && !blk) begin
      w = w_inc ? w + 16'd1 : w - 16'd1;
      if (w_sel[2]) mpc = w;
      else begin m[2*w_sel[1:0]] = w[15:8]; m[2*w_sel[1:0]+1] = w[7:0]; end
    end
    if (bw_en) m[bw_sel] = bus_in;
    if (pcw_en) begin
      if (pcw_hi) mpc[15:8] = bus_in; else mpc[7:0] = bus_in;
    end
  endtask

  task automatic cyc();
    #1 compare_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    bw_en = 0; pcw_en = 0; w_inc = 0; w_dec = 0;
  endtask

  task automatic wbyte(input logic [2:0] s, input logic [7:0] d);
    idle(); bw_en = 1; bw_sel = s; bus_in = d; cyc(); idle();
  endtask

  task automatic wpc(input logic hi, input logic [7:0] d);
    idle(); pcw_en = 1; pcw_hi = hi; bus_in = d; cyc(); idle();
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    mpc = 16'h0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    for (int k = 0; k < 8; k++) begin
      br_pc = 0; br_sel = 3'(k); #1 check("R1", bus_out, 8'h00); #1;
    end
    br_pc = 1; br_pc_hi = 1; #1 check("R1", bus_out, 8'h00);
    br_pc_hi = 0; #1 check("R1", bus_out, 8'h00);
    br_pc = 0;

    // R3: pair byte order, B high of BC
    wbyte(3'd0, 8'h12); wbyte(3'd1, 8'h34);
    a_sel = 3'd0; ale = 1; #1 check("R3", {addr_hi, ad_lane}, 16'h1234);
    a_sel = 3'd2; #1;
    wbyte(3'd4, 8'hAB); wbyte(3'd5, 8'hCD);
    #1 check("R3", {addr_hi, ad_lane}, 16'hABCD);

    // R9: lane carries data when ale low
    ale = 0; lane_data = 8'h5A; #1 check("R9", ad_lane, 8'h5A); ale = 1;

    // R5: PC wrap FFFF -> 0000
    wpc(1'b1, 8'hFF); wpc(1'b0, 8'hFF);
    a_sel = 3'd4; w_sel = 3'd4; w_inc = 1; cyc(); idle();
    #1 check("R5", {addr_hi, ad_lane}, 16'h0000);

    // R6: DE wrap 0000 -> FFFF
    a_sel = 3'd1; w_sel = 3'd1; w_dec = 1; cyc(); idle();
    #1 check("R6", {addr_hi, ad_lane}, 16'hFFFF);

    // R7: inc and dec together leave SP unchanged
    wbyte(3'd6, 8'h80); wbyte(3'd7, 8'h00);
    a_sel = 3'd3; w_sel = 3'd3; w_inc = 1; w_dec = 1; cyc(); idle();
    #1 check("R7", {addr_hi, ad_lane}, 16'h8000);

    // R8: byte write to L blocks HL increment in same cycle
    a_sel = 3'd2; w_sel = 3'd2; w_inc = 1; bw_en = 1; bw_sel = 3'd5; bus_in = 8'hFF;
    cyc(); idle();
    #1 check("R8", {addr_hi, ad_lane}, 16'hABFF);

    // R4: PC byte read path
    wpc(1'b1, 8'h3C); br_pc = 1; br_pc_hi = 1; #1 check("R4", bus_out, 8'h3C); br_pc = 0;

    // mixed random traffic, compared every cycle
    for (int n = 0; n < 4000; n++) begin
      bw_en = ($urandom % 3) == 0; bw_sel = 3'($urandom);
      pcw_en = ($urandom % 6) == 0; pcw_hi = 1'($urandom);
      bus_in = 8'($urandom); lane_data = 8'($urandom);
      br_sel = 3'($urandom); br_pc = ($urandom % 4) == 0; br_pc_hi = 1'($urandom);
      w_sel = 3'($urandom); w_inc = 1'($urandom); w_dec = 1'($urandom);
      a_sel = 3'($urandom); ale = 1'($urandom);
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule